// File: doc/BRIEF.md
# Byte-Wide Flash Command Interpreter

This block decodes the write cycles that a host issues to a byte-wide parallel flash device and turns them into embedded operations on a small internal byte array. It accepts three kinds of input. The first is the ordinary unlocked program sequence. The second is a fast bypass mode, in which each program needs only two writes. The third is a six-write whole-array erase. While an embedded operation runs, the block holds a busy flag high, and any array read returns a status byte in place of the stored data.

A program can only clear bits. The new cell value is the old value ANDed with the written byte. Only an erase brings bits back to one. The erase first drives every location to zero, one location per cycle, then waits a set time, and then sets the whole array to all ones. A synchronous hardware reset input cancels any running operation at once and returns the command decoder to array-read mode. It leaves any cells that were already written unchanged.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After `rst_n` is released, `busy` is 0, every array byte reads FFh, and the decoder is in array-read mode.
- R2: The write sequence AAh@555h, 55h@2AAh, A0h@555h, then data@address starts a program. `busy` is high for exactly PROG_CYCLES cycles, and afterwards the cell at address mod DEPTH holds the new value.
- R3: A program stores the old byte ANDed with the written byte, so a bit that is 0 stays 0.
- R4: A write with the wrong address or the wrong data at any step of an unlock sequence returns the decoder to array-read mode, and no operation starts.
- R5: AAh@555h, 55h@2AAh, 20h@555h enters bypass mode. In bypass mode, A0h at any address followed by data@address programs the cell, and the decoder stays in bypass mode afterwards.
- R6: In bypass mode, every write other than A0h or 90h as the first byte is ignored. This includes a complete erase sequence. Bypass mode stays active.
- R7: In bypass mode, 90h then 00h at any addresses returns the decoder to array-read mode. After that, A0h followed by data no longer programs.
- R8: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h starts an erase. `busy` is high for DEPTH+ERASE_CYCLES cycles, and afterwards every byte reads FFh.
- R9: During an erase, location i is set to 00h in the (i+1)-th busy cycle. The all-ones fill happens only in the final busy cycle.
- R10: Writes that arrive while `busy` is high are ignored. After the operation ends, the decoder is in array-read mode, or in bypass mode if the program was a bypass program.
- R11: While `busy` is high, `rd_data` reads 00h during an erase. During a program it reads the inverse of bit 7 of the programmed byte in bit 7, with zeros in all other bits.
- R12: `hw_rst` high at a clock edge stops any operation (`busy` is 0 after that edge), makes no array change at that edge, and puts the decoder in array-read mode, leaving bypass mode if it was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low; also fills the array with ones |
| hw_rst | input | 1 | Synchronous hardware reset; stops operations and returns to read mode |
| wr_en | input | 1 | Bus write strobe, one write per cycle in which it is high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | ADDR_W | Read address (mod DEPTH) |
| rd_data | output | 8 | Array byte, or a status byte while busy |
| busy | output | 1 | High while an embedded program or erase is running |

## Verification
The case that is hardest to reach is an erase stopped part way through. In that state the zero pass has covered only some locations, and this can only be seen once reads return data again. The stimulus first programs a cell above the zero pass region. It then starts an erase and asserts `hw_rst` a set number of cycles later. Afterwards it reads the zeroed low locations, the untouched programmed cell and the top location. A behavioural model runs alongside the design, advancing a cell index once per erase cycle and counting program cycles down. The model is compared with `busy` and `rd_data` on every clock, so the exact number of zeroed locations and the status byte are checked cycle by cycle.

// File: rtl/fcsm_pkg.sv
package fcsm_pkg;
   localparam int BYTE_W = 8;
   localparam int CMD_AW = 11;
   localparam logic [CMD_AW-1:0] UL_ADDR_A = 11'h555;
   localparam logic [CMD_AW-1:0] UL_ADDR_B = 11'h2AA;
   localparam logic [BYTE_W-1:0] KEY_A      = 8'hAA;
   localparam logic [BYTE_W-1:0] KEY_B      = 8'h55;
   localparam logic [BYTE_W-1:0] OP_PROGRAM = 8'hA0;
   localparam logic [BYTE_W-1:0] OP_ERSETUP = 8'h80;
   localparam logic [BYTE_W-1:0] OP_ERCHIP  = 8'h10;
   localparam logic [BYTE_W-1:0] OP_FASTIN  = 8'h20;
   localparam logic [BYTE_W-1:0] OP_FASTX1  = 8'h90;
   localparam logic [BYTE_W-1:0] OP_FASTX2  = 8'h00;

   typedef enum logic [3:0] {
      C_READ, C_KEY1, C_KEY2, C_PGM_TGT,
      C_ER_SET, C_ER_KEY1, C_ER_KEY2,
      C_FAST, C_FAST_TGT, C_FAST_EXIT
   } cmd_state_e;

   typedef enum logic [1:0] {
      X_IDLE, X_PROG, X_ZERO, X_SETTLE
   } exec_state_e;
endpackage

// File: rtl/fcsm_decode.sv
module fcsm_decode
   import fcsm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_rst,
   input  logic              wr_en,
   input  logic [CMD_AW-1:0] cmd_addr,
   input  logic [BYTE_W-1:0] cmd_byte,
   input  logic              eng_busy,
   output logic              pgm_go,
   output logic              erase_go
);
   cmd_state_e st_q, st_d;
   logic       take;
   logic       at_a, at_b;

   assign take = wr_en & ~eng_busy;
   assign at_a = (cmd_addr == UL_ADDR_A);
   assign at_b = (cmd_addr == UL_ADDR_B);

   always_comb begin
      st_d     = st_q;
      pgm_go   = 1'b0;
      erase_go = 1'b0;
      if (take) begin
         unique case (st_q)
            C_READ:    st_d = (at_a && cmd_byte == KEY_A) ? C_KEY1 : C_READ;
            C_KEY1:    st_d = (at_b && cmd_byte == KEY_B) ? C_KEY2 : C_READ;
            C_KEY2: begin
               if (at_a && cmd_byte == OP_PROGRAM)      st_d = C_PGM_TGT;
               else if (at_a && cmd_byte == OP_ERSETUP) st_d = C_ER_SET;
               else if (at_a && cmd_byte == OP_FASTIN)  st_d = C_FAST;
               else                                     st_d = C_READ;
            end
            C_PGM_TGT: begin
               pgm_go = 1'b1;
               st_d   = C_READ;
            end
            C_ER_SET:  st_d = (at_a && cmd_byte == KEY_A) ? C_ER_KEY1 : C_READ;
            C_ER_KEY1: st_d = (at_b && cmd_byte == KEY_B) ? C_ER_KEY2 : C_READ;
            C_ER_KEY2: begin
               erase_go = at_a && (cmd_byte == OP_ERCHIP);
               st_d     = C_READ;
            end
            C_FAST: begin
               if (cmd_byte == OP_PROGRAM)     st_d = C_FAST_TGT;
               else if (cmd_byte == OP_FASTX1) st_d = C_FAST_EXIT;
               else                            st_d = C_FAST;
            end
            C_FAST_TGT: begin
               pgm_go = 1'b1;
               st_d   = C_FAST;
            end
            C_FAST_EXIT: st_d = (cmd_byte == OP_FASTX2) ? C_READ : C_FAST;
            default:     st_d = C_READ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q <= C_READ;
      else if (hw_rst) st_q <= C_READ;
      else             st_q <= st_d;
   end
endmodule

// File: rtl/fcsm_engine.sv
module fcsm_engine
   import fcsm_pkg::*;
#(
   parameter int DEPTH        = 64,
   parameter int PROG_CYCLES  = 4,
   parameter int ERASE_CYCLES = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     hw_rst,
   input  logic                     pgm_go,
   input  logic                     erase_go,
   input  logic [$clog2(DEPTH)-1:0] tgt_idx,
   input  logic [BYTE_W-1:0]        tgt_byte,
   output logic                     busy,
   output logic                     erasing,
   output logic                     poll_bit,
   output logic                     commit_en,
   output logic [$clog2(DEPTH)-1:0] commit_idx,
   output logic [BYTE_W-1:0]        commit_byte,
   output logic                     zero_en,
   output logic [$clog2(DEPTH)-1:0] zero_idx,
   output logic                     fill_en
);
   localparam int IDX_W   = $clog2(DEPTH);
   localparam int CNT_MAX = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   exec_state_e       st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  tgt_q;
   logic [BYTE_W-1:0] pat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= X_IDLE;
         cnt_q <= '0;
         idx_q <= '0;
         tgt_q <= '0;
         pat_q <= '0;
      end else if (hw_rst) begin
         st_q <= X_IDLE;
      end else begin
         unique case (st_q)
            X_IDLE: begin
               if (pgm_go) begin
                  st_q  <= X_PROG;
                  cnt_q <= CNT_W'(PROG_CYCLES - 1);
                  tgt_q <= tgt_idx;
                  pat_q <= tgt_byte;
               end else if (erase_go) begin
                  st_q  <= X_ZERO;
                  idx_q <= '0;
               end
            end
            X_PROG: begin
               if (cnt_q == '0) st_q <= X_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
            X_ZERO: begin
               if (idx_q == IDX_W'(DEPTH - 1)) begin
                  st_q  <= X_SETTLE;
                  cnt_q <= CNT_W'(ERASE_CYCLES - 1);
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            X_SETTLE: begin
               if (cnt_q == '0) st_q <= X_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= X_IDLE;
         endcase
      end
   end

   assign busy        = (st_q != X_IDLE);
   assign erasing     = (st_q == X_ZERO) || (st_q == X_SETTLE);
   assign poll_bit    = ~pat_q[BYTE_W-1];
   assign commit_en   = (st_q == X_PROG) && (cnt_q == '0) && !hw_rst;
   assign commit_idx  = tgt_q;
   assign commit_byte = pat_q;
   assign zero_en     = (st_q == X_ZERO) && !hw_rst;
   assign zero_idx    = idx_q;
   assign fill_en     = (st_q == X_SETTLE) && (cnt_q == '0) && !hw_rst;
endmodule

// File: rtl/fcsm_array.sv
module fcsm_array
   import fcsm_pkg::*;
#(
   parameter int DEPTH = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     commit_en,
   input  logic [$clog2(DEPTH)-1:0] commit_idx,
   input  logic [BYTE_W-1:0]        commit_byte,
   input  logic                     zero_en,
   input  logic [$clog2(DEPTH)-1:0] zero_idx,
   input  logic                     fill_en,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [BYTE_W-1:0]        rd_byte
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [BYTE_W-1:0] rows [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_row
      logic [BYTE_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= '1;
         else if (fill_en)
            cell_q <= '1;
         else if (zero_en && zero_idx == IDX_W'(i))
            cell_q <= '0;
         else if (commit_en && commit_idx == IDX_W'(i))
            cell_q <= cell_q & commit_byte;
      end
      assign rows[i] = cell_q;
   end

   assign rd_byte = rows[rd_idx];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
   import fcsm_pkg::*;
#(
   parameter int ADDR_W       = 11,
   parameter int DEPTH        = 64,
   parameter int PROG_CYCLES  = 4,
   parameter int ERASE_CYCLES = 8,
   parameter bit POLL_STATUS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hw_rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   output logic              busy
);
   localparam int IDX_W = $clog2(DEPTH);

   if (ADDR_W < CMD_AW) begin : g_chk_aw
      $error("ADDR_W must cover the unlock addresses");
   end
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH || IDX_W >= ADDR_W) begin : g_chk_depth
      $error("DEPTH must be a power of two of at least 2, addressed by fewer bits than ADDR_W");
   end
   if (PROG_CYCLES < 1 || ERASE_CYCLES < 1) begin : g_chk_cycles
      $error("operation cycle counts must be at least 1");
   end

   logic              pgm_go, erase_go;
   logic              erasing, poll_bit;
   logic              commit_en, zero_en, fill_en;
   logic [IDX_W-1:0]  commit_idx, zero_idx;
   logic [7:0]        commit_byte, arr_byte, prog_status;
   logic              unused_rd_hi;

   assign unused_rd_hi = ^rd_addr[ADDR_W-1:IDX_W];

   fcsm_decode u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_rst   (hw_rst),
      .wr_en    (wr_en),
      .cmd_addr (wr_addr[CMD_AW-1:0]),
      .cmd_byte (wr_data),
      .eng_busy (busy),
      .pgm_go   (pgm_go),
      .erase_go (erase_go)
   );

   fcsm_engine #(
      .DEPTH        (DEPTH),
      .PROG_CYCLES  (PROG_CYCLES),
      .ERASE_CYCLES (ERASE_CYCLES)
   ) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .hw_rst      (hw_rst),
      .pgm_go      (pgm_go),
      .erase_go    (erase_go),
      .tgt_idx     (wr_addr[IDX_W-1:0]),
      .tgt_byte    (wr_data),
      .busy        (busy),
      .erasing     (erasing),
      .poll_bit    (poll_bit),
      .commit_en   (commit_en),
      .commit_idx  (commit_idx),
      .commit_byte (commit_byte),
      .zero_en     (zero_en),
      .zero_idx    (zero_idx),
      .fill_en     (fill_en)
   );

   fcsm_array #(.DEPTH(DEPTH)) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit_en   (commit_en),
      .commit_idx  (commit_idx),
      .commit_byte (commit_byte),
      .zero_en     (zero_en),
      .zero_idx    (zero_idx),
      .fill_en     (fill_en),
      .rd_idx      (rd_addr[IDX_W-1:0]),
      .rd_byte     (arr_byte)
   );

   if (POLL_STATUS) begin : g_poll
      assign prog_status = {poll_bit, 7'b0};
   end else begin : g_flat
      logic unused_poll;
      assign unused_poll = poll_bit;
      assign prog_status = 8'h00;
   end

   assign rd_data = !busy   ? arr_byte :
                    erasing ? 8'h00    : prog_status;
endmodule

// File: rtl/fcsm_checker.sv
module fcsm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       hw_rst,
   input logic       busy,
   input logic       erasing,
   input logic       pgm_go,
   input logic       erase_go,
   input logic [7:0] rd_data
);
   // R10: the decoder never launches while the engine is busy
   a_r10_no_launch_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(pgm_go || erase_go));

   // R2: an accepted launch makes the engine busy at the next edge
   a_r2_busy_after_launch: assert property (@(posedge clk) disable iff (!rst_n)
      ((pgm_go || erase_go) && !hw_rst) |=> busy);

   // R12: hardware reset leaves the engine idle
   a_r12_hwrst_idles: assert property (@(posedge clk) disable iff (!rst_n)
      hw_rst |=> !busy);

   // R11: reads during erase return the erase status byte
   a_r11_erase_status: assert property (@(posedge clk) disable iff (!rst_n)
      erasing |-> (rd_data == 8'h00));

   // R8: an erase stays busy across consecutive cycles unless reset
   a_r8_erase_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_go && !hw_rst) |=> (busy && erasing));
endmodule

bind flash_cmd_fsm fcsm_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hw_rst   (hw_rst),
   .busy     (busy),
   .erasing  (erasing),
   .pgm_go   (pgm_go),
   .erase_go (erase_go),
   .rd_data  (rd_data)
);

// File: tb/tb_flash_cmd_fsm.sv
module tb_flash_cmd_fsm;
   localparam int AW = 11;
   localparam int DEPTH = 64;
   localparam int PC = 4;
   localparam int EC = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hw_rst = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic          busy;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   flash_cmd_fsm #(.ADDR_W(AW), .DEPTH(DEPTH), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) dut (
      .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
   );

   // behavioural reference: mode step, remaining work, byte memory
   int         m_step, m_kind, m_cnt, m_el, m_pa;
   logic [7:0] m_pd;
   logic [7:0] mem [DEPTH];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_step = 0; m_kind = 0; m_cnt = 0; m_el = 0; m_pa = 0; m_pd = 8'h00;
         foreach (mem[i]) mem[i] = 8'hFF;
      end else if (hw_rst) begin
         m_step = 0; m_kind = 0;
      end else if (m_kind == 1) begin
         m_cnt = m_cnt - 1;
         if (m_cnt == 0) begin mem[m_pa] = mem[m_pa] & m_pd; m_kind = 0; end
      end else if (m_kind == 2) begin
         if (m_el < DEPTH) mem[m_el] = 8'h00;
         m_el = m_el + 1;
         if (m_el == DEPTH + EC) begin
            foreach (mem[i]) mem[i] = 8'hFF;
            m_kind = 0;
         end
      end else if (wr_en) begin
         case (m_step)
            0: m_step = (wr_addr == 11'h555 && wr_data == 8'hAA) ? 1 : 0;
            1: m_step = (wr_addr == 11'h2AA && wr_data == 8'h55) ? 2 : 0;
            2: if (wr_addr == 11'h555 && wr_data == 8'hA0) m_step = 3;
               else if (wr_addr == 11'h555 && wr_data == 8'h80) m_step = 4;
               else if (wr_addr == 11'h555 && wr_data == 8'h20) m_step = 10;
               else m_step = 0;
            3, 11: begin
               m_kind = 1; m_cnt = PC; m_pa = int'(wr_addr) % DEPTH; m_pd = wr_data;
               m_step = (m_step == 11) ? 10 : 0;
            end
            4: m_step = (wr_addr == 11'h555 && wr_data == 8'hAA) ? 5 : 0;
            5: m_step = (wr_addr == 11'h2AA && wr_data == 8'h55) ? 6 : 0;
            6: begin
               if (wr_addr == 11'h555 && wr_data == 8'h10) begin m_kind = 2; m_el = 0; end
               m_step = 0;
            end
            10: if (wr_data == 8'hA0) m_step = 11; else if (wr_data == 8'h90) m_step = 12;
            12: m_step = (wr_data == 8'h00) ? 0 : 10;
            default: m_step = 0;
         endcase
      end
   end

   // per-cycle comparison against the model (R2, R9, R11 timing)
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         logic [7:0] exp_rd;
         exp_rd = (m_kind == 1) ? {~m_pd[7], 7'b0} :
                  (m_kind == 2) ? 8'h00 : mem[int'(rd_addr) % DEPTH];
         tests++;
         if (busy !== (m_kind != 0) || rd_data !== exp_rd) begin
            fails++;
            $display("FAIL R9/R11 model t=%0t busy=%b rd=%h expected busy=%b rd=%h",
                     $time, busy, rd_data, (m_kind != 0), exp_rd);
         end
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
      @(negedge clk); rd_addr = a; #1; v = rd_data;
   endtask

   task automatic unlock();
      wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy && n < 1000) begin n++; @(negedge clk); end
   endtask

   task automatic std_prog(logic [AW-1:0] a, logic [7:0] d);
      int n;
      unlock(); wr(11'h555, 8'hA0); wr(a, d); count_busy(n);
   endtask

   task automatic erase_start();
      unlock(); wr(11'h555, 8'h80); unlock(); wr(11'h555, 8'h10);
   endtask

   task automatic pulse_hw();
      @(negedge clk); hw_rst = 1'b1;
      @(negedge clk); hw_rst = 1'b0;
   endtask

   initial begin
      logic [7:0] v;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 busy", {7'b0, busy}, 8'h00);
      rd(11'd0, v);  chk("R1 cell 0", v, 8'hFF);
      rd(11'd63, v); chk("R1 cell 63", v, 8'hFF);

      // R2 / R11: standard program with status and busy length
      unlock(); wr(11'h555, 8'hA0); wr(11'd5, 8'h3C);
      chk("R11 program status", rd_data, 8'h80);
      count_busy(n);
      chk("R2 busy cycles", 8'(n), 8'(PC));
      rd(11'd5, v); chk("R2 programmed cell", v, 8'h3C);

      // R3: AND-only programming
      std_prog(11'd5, 8'hF0);
      rd(11'd5, v); chk("R3 and result", v, 8'h30);

      // R10: writes during a program are ignored
      unlock(); wr(11'h555, 8'hA0); wr(11'd6, 8'h8F);
      chk("R11 status bit7 set data", rd_data, 8'h00);
      wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
      count_busy(n);
      wr(11'h555, 8'hA0); wr(11'd7, 8'h00);
      rd(11'd7, v); chk("R10 busy writes ignored", v, 8'hFF);
      rd(11'd6, v); chk("R2 second program", v, 8'h8F);

      // R4: broken sequences return to read mode
      unlock(); wr(11'h554, 8'hA0); wr(11'd8, 8'h00);
      rd(11'd8, v); chk("R4 wrong address", v, 8'hFF);
      wr(11'h555, 8'hAA); wr(11'h2AA, 8'h56); wr(11'h555, 8'hA0); wr(11'd8, 8'h00);
      rd(11'd8, v); chk("R4 wrong data", v, 8'hFF);
      chk("R4 no busy", {7'b0, busy}, 8'h00);

      // R5: bypass mode programs
      unlock(); wr(11'h555, 8'h20);
      wr(11'h123, 8'hA0); wr(11'd9, 8'h12); count_busy(n);
      rd(11'd9, v); chk("R5 bypass program", v, 8'h12);
      wr(11'h000, 8'hA0); wr(11'd10, 8'h34); count_busy(n);
      rd(11'd10, v); chk("R5 bypass second", v, 8'h34);

      // R6: other writes ignored in bypass, including an erase sequence
      erase_start();
      @(negedge clk);
      chk("R6 no erase in bypass", {7'b0, busy}, 8'h00);
      wr(11'd11, 8'h00);
      rd(11'd11, v); chk("R6 stray write", v, 8'hFF);
      wr(11'h555, 8'hA0); wr(11'd11, 8'h0F); count_busy(n);
      rd(11'd11, v); chk("R6 bypass kept", v, 8'h0F);

      // R7: bypass exit
      wr(11'h3FF, 8'h90); wr(11'h001, 8'h00);
      wr(11'h555, 8'hA0); wr(11'd12, 8'h00);
      rd(11'd12, v); chk("R7 exit to read", v, 8'hFF);

      // R8 / R10: full erase with ignored writes during it
      erase_start();
      chk("R11 erase status", rd_data, 8'h00);
      unlock();
      count_busy(n);
      chk("R8 erase busy cycles", 8'(n + 4), 8'(DEPTH + EC));
      rd(11'd5, v);  chk("R8 cell 5", v, 8'hFF);
      rd(11'd63, v); chk("R8 cell 63", v, 8'hFF);
      wr(11'h555, 8'hA0); wr(11'd14, 8'h00);
      rd(11'd14, v); chk("R10 read mode after erase", v, 8'hFF);

      // R9 / R12: erase stopped by hardware reset
      std_prog(11'd40, 8'h55);
      erase_start();
      repeat (10) @(negedge clk);
      pulse_hw();
      chk("R12 busy cleared", {7'b0, busy}, 8'h00);
      rd(11'd0, v);  chk("R9 preprogram zero", v, 8'h00);
      rd(11'd40, v); chk("R12 untouched cell", v, 8'h55);
      rd(11'd63, v); chk("R12 no fill", v, 8'hFF);
      std_prog(11'd63, 8'h7E);
      rd(11'd63, v); chk("R12 read mode after abort", v, 8'h7E);

      // R12: hardware reset leaves bypass
      unlock(); wr(11'h555, 8'h20);
      pulse_hw();
      wr(11'h555, 8'hA0); wr(11'd13, 8'h00);
      rd(11'd13, v); chk("R12 bypass left", v, 8'hFF);

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         tests++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule